// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block is a synchronous static RAM with a flow-through read path and a built-in 2-bit burst address generator. Its depth and its number of 9-bit byte lanes are parameters. Address, write data and the synchronous controls are taken in on the rising clock edge. The word at the registered address then appears on the read port in the same cycle, with no output register in between.

A burst opens when either of two active-low start strobes is sampled low, and that edge loads the external address. One strobe serves the processor and the other serves the memory controller. Each later beat takes its low two address bits from a 2-bit counter, which steps only on cycles where the advance input is low. A static order pin chooses how those bits are formed: linear wrap-around or interleaved XOR. The upper address bits stay fixed for the whole burst.

Writes are self-timed at the clock edge. They are decoded from per-lane byte enables, a write enable and a global write enable. An asynchronous output enable and a sleep input gate the read drive.

Top module: `flow_burst_sram`

## Requirements
- R1: A cycle with `start_cpu_n_i` or `start_ctl_n_i` low loads `addr_i` at the rising edge. After that edge, `dq_o` shows the word stored at that address in the same cycle, with no extra register stage.
- R2: With `lin_order_i`=1, beat k of a burst uses low address bits (start[1:0] + k) mod 4. The upper bits stay those of the start address, so the fifth beat returns to the start word.
- R3: With `lin_order_i`=0, beat k uses low address bits start[1:0] XOR (k mod 4).
- R4: Consider a cycle with both strobes high, in a selected burst. The counter steps only when `adv_n_i`=0. With `adv_n_i`=1 the same address is kept.
- R5: Lane i is bits [9i+8:9i] of `dq_i`. It is written only when `bwe_n_i[i]`=0 and `we_n_i`=0 in a write-capable cycle. With `we_n_i`=1 and `gwe_n_i`=1, nothing is written.
- R6: `gwe_n_i`=0 writes every lane, whatever `bwe_n_i` and `we_n_i` are. All lanes are also written when `we_n_i`=0 and all `bwe_n_i` bits are 0.
- R7: A cycle with `start_cpu_n_i`=0 is always a read, and all write controls are ignored. This holds even when `start_ctl_n_i` is also 0; the processor strobe wins.
- R8: A start cycle with `ce_n_i`=1 deselects the device. `dq_oe_o` is 0 from the next cycle until a start with `ce_n_i`=0. Continue cycles while deselected neither write nor advance.
- R9: `dq_oe_o`=1 only when the device is selected, the last registered cycle was not a write, `oe_n_i`=0 and `sleep_i`=0. `oe_n_i` acts without a clock edge. When `dq_oe_o`=0, `dq_o` is all zeros.
- R10: While `sleep_i`=1, clock edges are ignored: no write, no address or counter change. The array holds its contents and `dq_oe_o`=0. After wake-up, reads resume at the held address.
- R11: From power-up the device is deselected, so `dq_oe_o`=0 until the first selected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| sleep_i | input | 1 | Low-power hold, active high, not registered |
| addr_i | input | $clog2(DEPTH) | Word address, registered on start cycles |
| start_cpu_n_i | input | 1 | Processor burst start, active low, read only |
| start_ctl_n_i | input | 1 | Controller burst start, active low |
| ce_n_i | input | 1 | Chip select sampled on start cycles, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| lin_order_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| bwe_n_i | input | LANES | Per-lane byte write enables, active low |
| we_n_i | input | 1 | Write enable qualifying byte enables, active low |
| gwe_n_i | input | 1 | Global write of all lanes, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Flow-through read data |
| dq_oe_o | output | 1 | Read data drive enable; 0 means the pad is high-impedance |

## Verification
The bench builds the block with DEPTH=16 and LANES=2, which gives an 18-bit word. With that size it can fill and read back every address. It starts a four-beat-plus-wrap burst from each of the sixteen start positions in both orders. It applies every one of the four byte-lane masks, and it mixes in continue-cycle writes. The small array keeps a full reference copy in the bench cheap. Because of that copy, a strobe-priority, deselect or sleep cycle that wrongly touches any word shows up on a later read.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   // Low two address bits of burst beat 'cnt' from start bits 'base'.
   function automatic logic [1:0] seq_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       lin);
      return lin ? (base + cnt) : (base ^ cnt);
   endfunction

endpackage

// File: rtl/fbs_burst_ctr.sv
module fbs_burst_ctr
   import fbs_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk_i,
   input  logic          hold_i,
   input  logic          load_i,
   input  logic          step_i,
   input  logic          lin_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] cur_addr_o,
   output logic [AW-1:0] nxt_addr_o
);
   localparam int HW = AW - 2;

   logic [HW-1:0] hi_q   = '0;
   logic [1:0]    base_q = '0;
   logic [1:0]    cnt_q  = '0;
   logic [1:0]    cnt_d;

   always_comb begin
      cnt_d      = step_i ? cnt_q + 2'd1 : cnt_q;
      cur_addr_o = {hi_q, seq_low(base_q, cnt_q, lin_i)};
      nxt_addr_o = load_i ? addr_i : {hi_q, seq_low(base_q, cnt_d, lin_i)};
   end

   always_ff @(posedge clk_i) begin
      if (!hold_i) begin
         if (load_i) begin
            hi_q   <= addr_i[AW-1:2];
            base_q <= addr_i[1:0];
            cnt_q  <= 2'd0;
         end else begin
            cnt_q  <= cnt_d;
         end
      end
   end

   // R1: a load presents exactly the external address after the edge
   p_load_lands_r1: assert property (@(posedge clk_i) disable iff (hold_i)
      load_i |=> (cur_addr_o == $past(addr_i)));

   // R2: linear step increments the low bits and keeps the upper bits
   p_linear_step_r2: assert property (@(posedge clk_i) disable iff (hold_i)
      (step_i && !load_i && lin_i) |=>
         (cur_addr_o[1:0] == $past(cur_addr_o[1:0]) + 2'd1) &&
         (cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])));

   // R4: no load and no step keeps the burst state
   p_idle_holds_r4: assert property (@(posedge clk_i) disable iff (hold_i)
      (!load_i && !step_i) |=> ($stable(cnt_q) && $stable(base_q) && $stable(hi_q)));

   // R10: sleep freezes the burst state
   p_sleep_freeze_r10: assert property (@(posedge clk_i)
      hold_i |=> ($stable(cnt_q) && $stable(base_q) && $stable(hi_q)));

endmodule

// File: rtl/fbs_lane_dec.sv
module fbs_lane_dec #(
   parameter int LANES = 4
) (
   input  logic             wr_ok_i,
   input  logic             we_n_i,
   input  logic             gwe_n_i,
   input  logic [LANES-1:0] bwe_n_i,
   output logic [LANES-1:0] lane_we_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we_o[g] = wr_ok_i & (~gwe_n_i | (~we_n_i & ~bwe_n_i[g]));
   end
endmodule

// File: rtl/fbs_array.sv
module fbs_array #(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk_i,
   input  logic [LANES-1:0]          lane_we_i,
   input  logic [$clog2(DEPTH)-1:0]  waddr_i,
   input  logic [LANES*LANE_W-1:0]   wdata_i,
   input  logic [$clog2(DEPTH)-1:0]  raddr_i,
   output logic [LANES*LANE_W-1:0]   rdata_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk_i) begin
         if (lane_we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end

      assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
   end
endmodule

// File: rtl/flow_burst_sram.sv
module flow_burst_sram
   import fbs_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                     clk_i,
   input  logic                     sleep_i,
   input  logic [$clog2(DEPTH)-1:0] addr_i,
   input  logic                     start_cpu_n_i,
   input  logic                     start_ctl_n_i,
   input  logic                     ce_n_i,
   input  logic                     adv_n_i,
   input  logic                     lin_order_i,
   input  logic [LANES-1:0]         bwe_n_i,
   input  logic                     we_n_i,
   input  logic                     gwe_n_i,
   input  logic                     oe_n_i,
   input  logic [LANES*LANE_W-1:0]  dq_i,
   output logic [LANES*LANE_W-1:0]  dq_o,
   output logic                     dq_oe_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int W  = LANES * LANE_W;

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("LANES and LANE_W must be positive");
   end

   logic sel_q = 1'b0;
   logic wr_q  = 1'b0;

   logic             awake, cpu_go, ctl_go, any_start;
   logic             load, step, wr_ok;
   logic [LANES-1:0] lane_we;
   logic [AW-1:0]    cur_addr, nxt_addr;
   logic [W-1:0]     rdata;

   always_comb begin
      awake     = ~sleep_i;
      cpu_go    = ~start_cpu_n_i;
      ctl_go    = ~start_ctl_n_i & start_cpu_n_i;
      any_start = cpu_go | ctl_go;
      load      = awake & any_start;
      step      = awake & ~any_start & sel_q & ~adv_n_i;
      wr_ok     = awake & (ctl_go ? ~ce_n_i : (~any_start & sel_q));
   end

   fbs_burst_ctr #(.AW(AW)) i_ctr (
      .clk_i      (clk_i),
      .hold_i     (sleep_i),
      .load_i     (load),
      .step_i     (step),
      .lin_i      (lin_order_i),
      .addr_i     (addr_i),
      .cur_addr_o (cur_addr),
      .nxt_addr_o (nxt_addr)
   );

   fbs_lane_dec #(.LANES(LANES)) i_dec (
      .wr_ok_i   (wr_ok),
      .we_n_i    (we_n_i),
      .gwe_n_i   (gwe_n_i),
      .bwe_n_i   (bwe_n_i),
      .lane_we_o (lane_we)
   );

   fbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
      .clk_i     (clk_i),
      .lane_we_i (lane_we),
      .waddr_i   (nxt_addr),
      .wdata_i   (dq_i),
      .raddr_i   (cur_addr),
      .rdata_o   (rdata)
   );

   always_ff @(posedge clk_i) begin
      if (awake) begin
         if (any_start) sel_q <= ~ce_n_i;
         wr_q <= |lane_we;
      end
   end

   assign dq_oe_o = sel_q & ~wr_q & ~oe_n_i & ~sleep_i;
   assign dq_o    = dq_oe_o ? rdata : '0;

   // R7: processor-started cycles never write
   p_cpu_no_write_r7: assert property (@(posedge clk_i) disable iff (sleep_i)
      !start_cpu_n_i |-> (lane_we == '0));

   // R6: a selected controller start with global write writes every lane
   p_gwe_all_r6: assert property (@(posedge clk_i) disable iff (sleep_i)
      (start_cpu_n_i && !start_ctl_n_i && !ce_n_i && !gwe_n_i) |-> (&lane_we));

   // R5: without write enable or global write, nothing is written
   p_lane_needs_we_r5: assert property (@(posedge clk_i) disable iff (sleep_i)
      (gwe_n_i && we_n_i) |-> (lane_we == '0));

   // R8: a deselecting start silences the outputs on the next cycle
   p_hiz_after_deselect_r8: assert property (@(posedge clk_i) disable iff (sleep_i)
      (any_start && ce_n_i) |=> !dq_oe_o);

   // R9: no drive in the cycle after a write
   p_no_drive_after_write_r9: assert property (@(posedge clk_i) disable iff (sleep_i)
      (|lane_we) |=> !dq_oe_o);

   // R10: sleeping device never drives and never writes
   p_sleep_quiet_r10: assert property (@(posedge clk_i)
      sleep_i |-> (!dq_oe_o && lane_we == '0));

endmodule

// File: tb/test_flow_burst_sram.sv
`timescale 1ns/1ps
module test_flow_burst_sram;
   localparam int DEPTH = 16;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int W     = LANES * LW;
   localparam realtime TCLK = 8.0;

   logic         clk = 1'b0;
   logic         sleep_i = 1'b0;
   logic [3:0]   addr = '0;
   logic         start_cpu_n = 1'b1, start_ctl_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1;
   logic         lin = 1'b1;
   logic [1:0]   bwe_n = 2'b11;
   logic         we_n = 1'b1, gwe_n = 1'b1, oe_n = 1'b0;
   logic [W-1:0] dq_i = '0;
   logic [W-1:0] dq_o;
   logic         dq_oe;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] refm [DEPTH];

   always #(TCLK/2) clk = ~clk;

   flow_burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW)) i_flow_burst_sram (
      .clk_i(clk), .sleep_i(sleep_i), .addr_i(addr),
      .start_cpu_n_i(start_cpu_n), .start_ctl_n_i(start_ctl_n), .ce_n_i(ce_n),
      .adv_n_i(adv_n), .lin_order_i(lin), .bwe_n_i(bwe_n), .we_n_i(we_n),
      .gwe_n_i(gwe_n), .oe_n_i(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe)
   );

   function automatic logic [W-1:0] pat(input int a, input int s);
      return W'(a * 1237 + s * 4099 + 5);
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                          input logic [1:0] m);
      logic [W-1:0] r = old;
      for (int i = 0; i < LANES; i++) if (m[i]) r[i*LW +: LW] = d[i*LW +: LW];
      return r;
   endfunction

   function automatic int beat(input int a, input int k, input logic l);
      int lo = a & 3;
      int f  = l ? ((lo + k) & 3) : (lo ^ (k & 3));
      return (a & 12) | f;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // flags are "asserted" (1 = active); bm is the mask of lanes enabled
   task automatic tick(input logic cpu, input logic ctl, input logic adv, input logic ce,
                       input logic we, input logic gwe, input logic [1:0] bm,
                       input logic [3:0] a, input logic [W-1:0] d);
      start_cpu_n = ~cpu; start_ctl_n = ~ctl; adv_n = ~adv; ce_n = ~ce;
      we_n = ~we; gwe_n = ~gwe; bwe_n = ~bm; addr = a; dq_i = d;
      @(posedge clk); #1;
   endtask

   task automatic rd(input int a);
      tick(1, 0, 0, 1, 0, 0, 2'b00, 4'(a), '0);
   endtask

   task automatic rd_chk(input string req, input int a);
      rd(a);
      chk(req, {17'd0, dq_oe}, {17'd0, 1'b1});
      chk(req, dq_o, refm[a]);
   endtask

   task automatic idle(input logic adv);
      tick(0, 0, adv, 1, 0, 0, 2'b00, 4'd0, '0);
   endtask

   initial begin
      #(TCLK * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11: power-up state is deselected
      idle(0);
      chk("R11 power-up drive", {17'd0, dq_oe}, '0);
      idle(1);
      chk("R11 idle advance", {17'd0, dq_oe}, '0);

      // Fill every address with global write; R9 no drive after write
      for (int a = 0; a < DEPTH; a++) begin
         tick(0, 1, 0, 1, 0, 1, 2'b00, 4'(a), pat(a, 0));
         refm[a] = pat(a, 0);
         chk("R9 drive after write", {17'd0, dq_oe}, '0);
      end

      // R1: flow-through single reads
      for (int a = 0; a < DEPTH; a++) rd_chk("R1 read", a);

      // R2 / R3: bursts from every start in both orders, including wrap
      for (int o = 0; o < 2; o++) begin
         lin = logic'(o);
         for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk(o ? "R2 beat0" : "R3 beat0", dq_o, refm[a]);
            for (int k = 1; k <= 4; k++) begin
               idle(1);
               chk(o ? "R2 linear beat" : "R3 interleaved beat", dq_o, refm[beat(a, k, lin)]);
            end
         end
      end
      lin = 1'b1;

      // R4: no advance keeps the address
      rd(5);
      idle(0);
      chk("R4 hold", dq_o, refm[5]);
      idle(0);
      chk("R4 hold", dq_o, refm[5]);
      idle(1);
      chk("R4 step", dq_o, refm[6]);

      // R5: each lane mask through a linear write burst 8..11
      tick(0, 1, 0, 1, 1, 0, 2'b01, 4'd8, pat(8, 1));
      refm[8] = merge(refm[8], pat(8, 1), 2'b01);
      tick(0, 0, 1, 1, 1, 0, 2'b10, 4'd0, pat(9, 1));
      refm[9] = merge(refm[9], pat(9, 1), 2'b10);
      tick(0, 0, 1, 1, 1, 0, 2'b11, 4'd0, pat(10, 1));
      refm[10] = merge(refm[10], pat(10, 1), 2'b11);
      tick(0, 0, 1, 1, 1, 0, 2'b00, 4'd0, pat(11, 1));
      for (int a = 8; a < 12; a++) rd_chk("R5 lane mask", a);

      // R5: byte enables without write enable write nothing
      tick(0, 1, 0, 1, 0, 0, 2'b11, 4'd1, pat(1, 2));
      rd_chk("R5 no we", 1);

      // R6: global write ignores byte enables; all byte enables + we also write all
      tick(0, 1, 0, 1, 0, 1, 2'b00, 4'd2, pat(2, 3));
      refm[2] = pat(2, 3);
      rd_chk("R6 global", 2);
      tick(0, 1, 0, 1, 1, 0, 2'b11, 4'd14, pat(14, 3));
      refm[14] = pat(14, 3);
      tick(0, 0, 1, 1, 1, 0, 2'b11, 4'd0, pat(15, 3));
      refm[15] = pat(15, 3);
      tick(0, 0, 1, 1, 1, 0, 2'b11, 4'd0, pat(12, 3));
      refm[12] = pat(12, 3);
      for (int a = 12; a < 16; a++) rd_chk("R6 all lanes", a);

      // R7: processor strobe wins and ignores writes
      tick(1, 1, 0, 1, 1, 1, 2'b11, 4'd3, pat(3, 4));
      chk("R7 both strobes read", dq_o, refm[3]);
      tick(1, 0, 0, 1, 0, 1, 2'b00, 4'd4, pat(4, 4));
      chk("R7 cpu read", dq_o, refm[4]);
      rd_chk("R7 unchanged", 3);
      rd_chk("R7 unchanged", 4);

      // R8: deselect silences outputs; continue cycles do nothing
      rd(2);
      tick(0, 1, 0, 0, 0, 0, 2'b00, 4'd7, '0);
      chk("R8 deselect", {17'd0, dq_oe}, '0);
      tick(0, 0, 1, 1, 1, 1, 2'b11, 4'd0, pat(7, 5));
      chk("R8 still off", {17'd0, dq_oe}, '0);
      rd_chk("R8 no write", 7);
      rd_chk("R8 no write", 8);

      // R9: asynchronous output enable
      rd(0);
      oe_n = 1'b1; #1;
      chk("R9 oe off", {17'd0, dq_oe}, '0);
      chk("R9 bus zero", dq_o, '0);
      oe_n = 1'b0; #1;
      chk("R9 oe on", dq_o, refm[0]);

      // R10: sleep ignores cycles and holds state
      rd(6);
      sleep_i = 1'b1; #1;
      chk("R10 sleep drive", {17'd0, dq_oe}, '0);
      tick(0, 1, 0, 1, 0, 1, 2'b00, 4'd6, pat(6, 6));
      tick(1, 0, 0, 1, 0, 0, 2'b00, 4'd9, '0);
      tick(0, 0, 1, 1, 0, 0, 2'b00, 4'd0, '0);
      chk("R10 sleep drive", {17'd0, dq_oe}, '0);
      sleep_i = 1'b0;
      idle(0);
      chk("R10 wake drive", {17'd0, dq_oe}, {17'd0, 1'b1});
      chk("R10 wake address", dq_o, refm[6]);
      rd_chk("R10 contents", 6);
      rd_chk("R10 contents", 9);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule